// File: doc/BRIEF.md
# Shared Lookup-Table Write Fabric

This block connects sixteen cores to the write side of sixteen lookup RAMs, one RAM per core, each 512 words of 32 bits. Any core can write into any RAM, its own included. A core presents a target mask with one bit per RAM, a 9-bit word address and a 32-bit value. It then chooses one of two ways to issue the write.

A fast write lands on the next clock edge. At every target RAM the fabric keeps only the sources whose mask bit for that RAM is set. It merges their addresses and data with a plain bitwise OR, and there is no arbitration. Two fast writers aimed at the same RAM in one cycle therefore deposit the OR of their values at the OR of their addresses. A safe write avoids this. The fabric latches the request and holds the core until a free-running slot counter reaches that core's index. It then commits the latched write and pulses a done flag. Since only one slot is live per cycle, safe writers never meet at a RAM.

A read tap lets one RAM word be observed through the ports.

Top module: `lut_write_fabric`

## Requirements
- R1: Fast writes from different cores into different RAMs in the same cycle each land intact, even when they use the same address.
- R2: A fast write (`cmd_fast[c]` high) stores `cmd_data` slice c at `cmd_addr` slice c in every RAM t whose bit t of mask slice c (`cmd_mask[c*16+t]`) is set, at the next clock edge.
- R3: When several sources write one RAM in the same cycle, that RAM stores the OR of their data at the OR of their addresses. The words at the individual addresses stay unchanged unless they equal the OR address.
- R4: A RAM is not written in a cycle in which no source has an active gated enable for it. A mask without `cmd_fast` or a pending safe commit has no effect.
- R5: `slot` counts up by one every clock cycle and wraps from 15 to 0. It reads 0 during reset.
- R6: A safe request (`cmd_safe[c]` high for one cycle) raises `safe_busy[c]` from the next cycle. `safe_done[c]` pulses in the one cycle where `slot` equals c, and the write commits at the end of that cycle. The pulse comes k cycles after the request cycle, with k = ((c - s - 1) mod 16) + 1, where s is the slot value in the request cycle, so k lies between 1 and 16. Busy drops the cycle after the done pulse.
- R7: At most one `safe_done` bit is high in any cycle. Two safe writes to the same RAM and cycle both land intact, and their OR address is not touched.
- R8: A safe write uses the mask, address and data captured in its request cycle. Later changes on those inputs have no effect on it, and a `cmd_safe` while busy is ignored.
- R9: Under reset, no safe write is pending, `safe_busy` and `safe_done` are zero, and no RAM write is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_fast | input | 16 | Per-core fast-write strobe |
| cmd_safe | input | 16 | Per-core safe-write request |
| cmd_mask | input | 256 | Target masks, core c at bits [c*16 +: 16] |
| cmd_addr | input | 144 | Word addresses, core c at [c*9 +: 9] |
| cmd_data | input | 512 | Write data, core c at [c*32 +: 32] |
| safe_busy | output | 16 | Core is stalled on a pending safe write |
| safe_done | output | 16 | Safe write committing this cycle |
| slot | output | 4 | Current slot counter value |
| peek_sel | input | 4 | RAM selected for the read tap |
| peek_addr | input | 9 | Word address for the read tap |
| peek_data | output | 32 | Word read from the selected RAM |

## Verification
The bench aims two fast writers at one RAM with disjoint address bits and disjoint data bits. A fabric that arbitrates, or that lets the last writer win, would leave a value at one of the individual addresses instead of at the merged one. The bench sends writers aimed at different RAMs through the same address to show that gating isolates them; a merge taken across all sources would smear one value into both RAMs. Safe writes start both one slot before their own and exactly on it. A wrong slot compare or an off-by-one capture would change the measured wait from 1 or 16 cycles. The bench also changes the inputs and re-requests during the stall, which would corrupt a design that does not latch its request.

// File: rtl/lutw_pkg.sv
package lutw_pkg;
  localparam int LUTW_CORES = 16;
  localparam int LUTW_AW    = 9;
  localparam int LUTW_DW    = 32;
endpackage

// File: rtl/lutw_slot_ctr.sv
module lutw_slot_ctr #(
  parameter int NCORE = 16,
  localparam int SW   = $clog2(NCORE)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] slot
);
  function automatic logic [SW-1:0] next_slot(input logic [SW-1:0] cur);
    return (cur == SW'(NCORE - 1)) ? '0 : cur + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else        slot <= next_slot(slot);
  end
endmodule

// File: rtl/lutw_safe_hold.sv
module lutw_safe_hold #(
  parameter int NCORE = 16,
  parameter int AW    = 9,
  parameter int DW    = 32,
  parameter int ID    = 0,
  localparam int SW   = $clog2(NCORE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SW-1:0]    slot,
  input  logic             req,
  input  logic [NCORE-1:0] mask_in,
  input  logic [AW-1:0]    addr_in,
  input  logic [DW-1:0]    data_in,
  output logic             busy,
  output logic             fire,
  output logic [NCORE-1:0] mask_q,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    data_q
);
  logic pend;
  logic take;

  assign take = req && !pend;
  assign fire = pend && (slot == SW'(ID));
  assign busy = pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend <= 1'b0;
    else if (take) pend <= 1'b1;
    else if (fire) pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (take) begin
      mask_q <= mask_in;
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end
endmodule

// File: rtl/lutw_merge.sv
module lutw_merge #(
  parameter int NCORE = 16,
  parameter int AW    = 9,
  parameter int DW    = 32
) (
  input  logic [NCORE-1:0]    src_en,
  input  logic [NCORE*AW-1:0] src_addr,
  input  logic [NCORE*DW-1:0] src_data,
  output logic                we,
  output logic [AW-1:0]       addr,
  output logic [DW-1:0]       data
);
  function automatic logic [AW-1:0] gate_addr(input logic en, input logic [AW-1:0] v);
    return en ? v : '0;
  endfunction

  function automatic logic [DW-1:0] gate_data(input logic en, input logic [DW-1:0] v);
    return en ? v : '0;
  endfunction

  always_comb begin
    we   = 1'b0;
    addr = '0;
    data = '0;
    for (int s = 0; s < NCORE; s++) begin
      we   = we | src_en[s];
      addr = addr | gate_addr(src_en[s], src_addr[s*AW +: AW]);
      data = data | gate_data(src_en[s], src_data[s*DW +: DW]);
    end
  end
endmodule

// File: rtl/lutw_ram.sv
module lutw_ram #(
  parameter int AW = 9,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lut_write_fabric.sv
module lut_write_fabric #(
  parameter int NCORE = lutw_pkg::LUTW_CORES,
  parameter int AW    = lutw_pkg::LUTW_AW,
  parameter int DW    = lutw_pkg::LUTW_DW,
  localparam int SW   = $clog2(NCORE)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCORE-1:0]       cmd_fast,
  input  logic [NCORE-1:0]       cmd_safe,
  input  logic [NCORE*NCORE-1:0] cmd_mask,
  input  logic [NCORE*AW-1:0]    cmd_addr,
  input  logic [NCORE*DW-1:0]    cmd_data,
  output logic [NCORE-1:0]       safe_busy,
  output logic [NCORE-1:0]       safe_done,
  output logic [SW-1:0]          slot,
  input  logic [SW-1:0]          peek_sel,
  input  logic [AW-1:0]          peek_addr,
  output logic [DW-1:0]          peek_data
);
  logic [SW-1:0]          slot_w;
  logic [NCORE-1:0]       fire;
  logic [NCORE*NCORE-1:0] held_mask;
  logic [NCORE*AW-1:0]    held_addr;
  logic [NCORE*DW-1:0]    held_data;
  logic [NCORE*NCORE-1:0] src_mask;
  logic [NCORE*AW-1:0]    src_addr;
  logic [NCORE*DW-1:0]    src_data;
  logic [NCORE-1:0]       tgt_we;
  logic [NCORE*AW-1:0]    tgt_addr;
  logic [NCORE*DW-1:0]    tgt_data;
  logic [DW-1:0]          rd_all [NCORE];

  lutw_slot_ctr #(.NCORE(NCORE)) u_slot (
    .clk(clk), .rst_n(rst_n), .slot(slot_w)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    lutw_safe_hold #(.NCORE(NCORE), .AW(AW), .DW(DW), .ID(c)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .slot    (slot_w),
      .req     (cmd_safe[c]),
      .mask_in (cmd_mask[c*NCORE +: NCORE]),
      .addr_in (cmd_addr[c*AW +: AW]),
      .data_in (cmd_data[c*DW +: DW]),
      .busy    (safe_busy[c]),
      .fire    (fire[c]),
      .mask_q  (held_mask[c*NCORE +: NCORE]),
      .addr_q  (held_addr[c*AW +: AW]),
      .data_q  (held_data[c*DW +: DW])
    );

    // A committing safe write owns this core's source lines for its slot.
    assign src_mask[c*NCORE +: NCORE] = fire[c]     ? held_mask[c*NCORE +: NCORE] :
                                        cmd_fast[c] ? cmd_mask[c*NCORE +: NCORE]  : '0;
    assign src_addr[c*AW +: AW] = fire[c] ? held_addr[c*AW +: AW] : cmd_addr[c*AW +: AW];
    assign src_data[c*DW +: DW] = fire[c] ? held_data[c*DW +: DW] : cmd_data[c*DW +: DW];
  end

  for (genvar t = 0; t < NCORE; t++) begin : g_tgt
    logic [NCORE-1:0] col_en;
    for (genvar s = 0; s < NCORE; s++) begin : g_col
      assign col_en[s] = src_mask[s*NCORE + t];
    end

    lutw_merge #(.NCORE(NCORE), .AW(AW), .DW(DW)) u_merge (
      .src_en   (col_en),
      .src_addr (src_addr),
      .src_data (src_data),
      .we       (tgt_we[t]),
      .addr     (tgt_addr[t*AW +: AW]),
      .data     (tgt_data[t*DW +: DW])
    );

    lutw_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk   (clk),
      .we    (tgt_we[t]),
      .waddr (tgt_addr[t*AW +: AW]),
      .wdata (tgt_data[t*DW +: DW]),
      .raddr (peek_addr),
      .rdata (rd_all[t])
    );
  end

  assign slot      = slot_w;
  assign safe_done = fire;
  assign peek_data = rd_all[peek_sel];
endmodule

// File: rtl/lut_write_fabric_chk.sv
module lut_write_fabric_chk #(
  parameter int NCORE = 16,
  parameter int AW    = 9,
  localparam int SW   = $clog2(NCORE)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SW-1:0]       slot,
  input logic [NCORE-1:0]    cmd_fast,
  input logic [NCORE-1:0]    cmd_safe,
  input logic [NCORE-1:0]    safe_busy,
  input logic [NCORE-1:0]    safe_done,
  input logic [NCORE-1:0]    tgt_we,
  input logic [NCORE*AW-1:0] held_addr
);
  a_r5_slot_advances: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> slot == (($past(slot) == SW'(NCORE - 1)) ? '0 : $past(slot) + 1'b1));

  a_r6_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (|safe_done) |=> ((safe_busy & $past(safe_done)) == '0));

  a_r7_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(safe_done));

  a_r4_quiet_ports: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|cmd_fast) && !(|safe_done)) |-> (tgt_we == '0));

  for (genvar i = 0; i < NCORE; i++) begin : g_chk
    a_r6_busy_after_request: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_safe[i] && !safe_busy[i]) |=> safe_busy[i]);

    a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
      (safe_busy[i] && !safe_done[i]) |=>
        (safe_busy[i] && (held_addr[i*AW +: AW] == $past(held_addr[i*AW +: AW]))));
  end
endmodule

bind lut_write_fabric lut_write_fabric_chk #(.NCORE(NCORE), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slot      (slot_w),
  .cmd_fast  (cmd_fast),
  .cmd_safe  (cmd_safe),
  .safe_busy (safe_busy),
  .safe_done (safe_done),
  .tgt_we    (tgt_we),
  .held_addr (held_addr)
);

// File: tb/sim_lut_write_fabric.sv
module sim_lut_write_fabric;
  localparam int N = 16;
  localparam int AW = 9;
  localparam int DW = 32;

  typedef struct packed {
    logic [3:0]  ca; logic [15:0] ma; logic [8:0] aa; logic [31:0] da;
    logic        useb;
    logic [3:0]  cb; logic [15:0] mb; logic [8:0] ab; logic [31:0] db;
    logic [1:0]  rq;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{4'd0,  16'h0002, 9'h010, 32'h11111111, 1'b1, 4'd2,  16'h0008, 9'h020, 32'h22222222, 2'd1},
    '{4'd5,  16'h0020, 9'h1FF, 32'hA5A5A5A5, 1'b0, 4'd0,  16'h0000, 9'h000, 32'h00000000, 2'd2},
    '{4'd4,  16'h0080, 9'h003, 32'h000000F0, 1'b1, 4'd9,  16'h0080, 9'h00C, 32'h0000000F, 2'd3},
    '{4'd15, 16'h8001, 9'h100, 32'hCAFE0001, 1'b0, 4'd0,  16'h0000, 9'h000, 32'h00000000, 2'd2},
    '{4'd1,  16'h0004, 9'h055, 32'h12340000, 1'b1, 4'd3,  16'h0004, 9'h0AA, 32'h00005678, 2'd3},
    '{4'd7,  16'h0100, 9'h040, 32'h0F0F0000, 1'b1, 4'd8,  16'h0100, 9'h040, 32'h00F000F0, 2'd3},
    '{4'd10, 16'h0800, 9'h077, 32'h0BAD0000, 1'b1, 4'd11, 16'h0400, 9'h077, 32'h0000600D, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    cmd_fast = '0;
  logic [N-1:0]    cmd_safe = '0;
  logic [N*N-1:0]  cmd_mask = '0;
  logic [N*AW-1:0] cmd_addr = '0;
  logic [N*DW-1:0] cmd_data = '0;
  logic [N-1:0]    safe_busy;
  logic [N-1:0]    safe_done;
  logic [3:0]      slot;
  logic [3:0]      peek_sel = '0;
  logic [AW-1:0]   peek_addr = '0;
  logic [DW-1:0]   peek_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] shadow [N][512];

  always #5 clk = ~clk;

  lut_write_fabric u0 (
    .clk(clk), .rst_n(rst_n), .cmd_fast(cmd_fast), .cmd_safe(cmd_safe),
    .cmd_mask(cmd_mask), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .safe_busy(safe_busy), .safe_done(safe_done), .slot(slot),
    .peek_sel(peek_sel), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_word(input string req, input int t, input logic [8:0] a);
    peek_sel  = 4'(t);
    peek_addr = a;
    #1;
    check(req, peek_data, shadow[t][a]);
  endtask

  task automatic set_core(input int c, input logic [15:0] m, input logic [8:0] a, input logic [31:0] d);
    cmd_mask[c*N +: N]   = m;
    cmd_addr[c*AW +: AW] = a;
    cmd_data[c*DW +: DW] = d;
  endtask

  task automatic clear_cmds();
    cmd_fast = '0; cmd_safe = '0; cmd_mask = '0; cmd_addr = '0; cmd_data = '0;
  endtask

  task automatic wait_slot(input logic [3:0] s);
    @(negedge clk);
    while (slot !== s) @(negedge clk);
  endtask

  // Safe write from core c; request issued while slot == s0 (R6, R8)
  task automatic safe_run(input int c, input int t, input logic [8:0] a, input logic [31:0] d,
                          input logic [3:0] s0);
    int k;
    int exp_k;
    logic [8:0] alt_a;
    alt_a = a ^ 9'h100;
    exp_k = ((c - int'(s0) - 1) & 15) + 1;
    wait_slot(s0);
    set_core(c, 16'(1 << t), a, d);
    cmd_safe[c] = 1'b1;
    @(negedge clk);
    cmd_safe[c] = 1'b0;
    set_core(c, 16'(1 << t), alt_a, ~d);  // R8: inputs move after capture
    k = 1;
    while (safe_done[c] !== 1'b1 && k < 20) begin
      check("R6 busy while waiting", 32'(safe_busy[c]), 32'd1);
      if (k == 2) cmd_safe[c] = 1'b1;     // R8: request while busy is ignored
      @(negedge clk);
      cmd_safe[c] = 1'b0;
      k++;
    end
    check("R6 wait cycles", 32'(k), 32'(exp_k));
    check("R6 slot at done", 32'(slot), 32'(c));
    check("R6 busy during done", 32'(safe_busy[c]), 32'd1);
    @(negedge clk);
    check("R6 busy drops after done", 32'(safe_busy[c]), 32'd0);
    clear_cmds();
    shadow[t][a] = d;
    check_word("R6 safe data landed", t, a);
    check_word("R8 moved inputs ignored", t, alt_a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] s0;
    for (int t = 0; t < N; t++)
      for (int a = 0; a < 512; a++) shadow[t][a] = '0;

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 slot in reset", 32'(slot), 32'd0);
    check("R9 busy in reset", 32'(safe_busy), 32'd0);
    check("R9 done in reset", 32'(safe_done), 32'd0);
    rst_n = 1'b1;

    // R5: free-running slot counter
    @(negedge clk);
    check("R5 first slot after reset", 32'(slot), 32'd1);
    s0 = slot;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      check("R5 slot step", 32'(slot), 32'((s0 + i) & 15));
    end

    // Table of fast-write patterns (R1 isolation, R2 single writer, R3 OR merge)
    for (int v = 0; v < 7; v++) begin
      string tag;
      tag = (VECS[v].rq == 2'd1) ? "R1" : (VECS[v].rq == 2'd2) ? "R2" : "R3";
      @(negedge clk);
      set_core(int'(VECS[v].ca), VECS[v].ma, VECS[v].aa, VECS[v].da);
      cmd_fast[VECS[v].ca] = 1'b1;
      if (VECS[v].useb) begin
        set_core(int'(VECS[v].cb), VECS[v].mb, VECS[v].ab, VECS[v].db);
        cmd_fast[VECS[v].cb] = 1'b1;
      end
      @(negedge clk);
      clear_cmds();
      for (int t = 0; t < N; t++) begin
        logic en;
        logic [8:0] ma;
        logic [31:0] md;
        en = 1'b0; ma = '0; md = '0;
        if (VECS[v].ma[t]) begin en = 1'b1; ma |= VECS[v].aa; md |= VECS[v].da; end
        if (VECS[v].useb && VECS[v].mb[t]) begin en = 1'b1; ma |= VECS[v].ab; md |= VECS[v].db; end
        if (en) shadow[t][ma] = md;
      end
      for (int t = 0; t < N; t++) begin
        check_word(tag, t, VECS[v].aa);
        if (VECS[v].useb) begin
          check_word(tag, t, VECS[v].ab);
          check_word(tag, t, VECS[v].aa | VECS[v].ab);
        end
      end
    end

    // R4: mask and data present but no strobe
    @(negedge clk);
    set_core(6, 16'h2000, 9'h033, 32'hDEADBEEF);
    @(negedge clk);
    clear_cmds();
    check_word("R4 no strobe no write", 13, 9'h033);

    // R6/R8: safe writes, shortest and longest waits, and a mid case
    safe_run(3, 6, 9'h077, 32'h5AFE0003, 4'd2);
    safe_run(3, 6, 9'h078, 32'h5AFE1003, 4'd3);
    safe_run(12, 0, 9'h0C4, 32'h5AFE000C, 4'd5);

    // R7: two safe writers, same target, same request cycle
    wait_slot(4'd0);
    set_core(4, 16'h0200, 9'h101, 32'h00AA0000);
    set_core(12, 16'h0200, 9'h202, 32'h000000BB);
    cmd_safe[4] = 1'b1;
    cmd_safe[12] = 1'b1;
    @(negedge clk);
    clear_cmds();
    for (int k = 1; k <= 13; k++) begin
      logic [15:0] exp_done;
      exp_done = (k == 4) ? 16'h0010 : (k == 12) ? 16'h1000 : 16'h0000;
      check("R7 done one at a time", 32'(safe_done), 32'(exp_done));
      @(negedge clk);
    end
    shadow[9][9'h101] = 32'h00AA0000;
    shadow[9][9'h202] = 32'h000000BB;
    check_word("R7 first safe writer", 9, 9'h101);
    check_word("R7 second safe writer", 9, 9'h202);
    check_word("R7 no merged location", 9, 9'h303);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule